// File: doc/BRIEF.md
# Sequential Nearest-Integer Square Root

This unit takes an unsigned radicand of `WIDTH` bits and returns a root of `WIDTH/2` bits, rounded to the nearest integer. `WIDTH` must be even and at least 4. The root is found by a binary search. A trial root starts at the midpoint of the root range. It moves up or down by an increment that halves on every step.

The unit does not square the trial root in each step. A second register holds that square, and each step updates it with a shifted copy of the trial root and the squared increment, so the datapath needs only adders and shifters. After the last search step, a single correction cycle compares the radicand with the held square minus and plus the trial root. That comparison moves the result down by one, up by one, or leaves it unchanged. Any result that would not fit in `WIDTH/2` bits is clamped to the largest value that does.

The block is driven with a single start strobe, and a one-cycle done pulse marks that the root output is ready. The root then stays on the output until the next operation completes.

Top module: `isqrt_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `root` is 0.
- R2: A `start` seen while the unit is idle captures `radicand`. `busy` is 1 from the following cycle until the correction cycle ends, which is `WIDTH/2` cycles in all.
- R3: `done` is high for exactly one cycle. It is first sampled high `WIDTH/2` clock edges after the edge that accepted `start`, which is 8 edges for the default `WIDTH` of 16.
- R4: For every radicand n, the result r satisfies r*r - r < n <= r*r + r, which makes r the integer nearest to the true square root. A zero radicand gives 0, and a perfect square gives its exact root.
- R5: When the rounded root would equal 2^(WIDTH/2), `root` is clamped to 2^(WIDTH/2) - 1. With the default width this covers radicands 65281 to 65535, which give 255.
- R6: A `start` that arrives while `busy` or `done` is high is ignored. The running operation keeps its operand, its latency and its result, and the unit is idle in the cycle after `done`.
- R7: `root` holds its value from one completed operation until the next one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; honoured only when idle |
| radicand | input | WIDTH | Unsigned operand, sampled with an accepted start |
| busy | output | 1 | Search or correction in progress |
| done | output | 1 | One-cycle pulse: `root` has just been updated |
| root | output | WIDTH/2 | Nearest-integer root, clamped to the root range |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and a request for the next one. A request can also arrive while the search is still running. The bench raises `start` with a different operand from the cycle after an operation is accepted, holds it through the cycle in which `done` is high, and only then releases it. It then checks three things. The root must still belong to the first operand. The latency must be unchanged. Afterwards `busy` must stay low and `root` must keep its value over the following idle cycles.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operand, seed trial root and square
    logic step;  // one binary-search step
    logic fix;   // nearest-rounding correction and clamp
  } sqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIX,
    ST_DONE
  } sqState_t;

endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int CNT_W  = $clog2(HALF_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output sqStrobe_t        strobe,
  output logic [CNT_W-1:0] shiftCnt,
  output logic             busy,
  output logic             done
);

  sqState_t         state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ITER;
          stepCnt <= CNT_W'(HALF_W - 1);
        end
        ST_ITER: begin
          stepCnt <= stepCnt - 1'b1;
          if (stepCnt == CNT_W'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_ITER);
    strobe.fix  = (state == ST_FIX);
  end

  assign shiftCnt = stepCnt;
  assign busy     = (state == ST_ITER) || (state == ST_FIX);
  assign done     = (state == ST_DONE);

  // Independent cycle counter used only by the checks below
  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk) begin
    if (!rst_n)     busyRun <= '0;
    else if (busy)  busyRun <= busyRun + 1'b1;
    else if (!done) busyRun <= '0;
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (busyRun == (CNT_W+1)'(HALF_W)));

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (done || busyRun == $past(busyRun) + 1'b1));

  assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath
  import isqrt_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HALF_W = WIDTH / 2,
  parameter int CNT_W  = $clog2(HALF_W),
  parameter int SQ_W   = WIDTH + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sqStrobe_t         strobe,
  input  logic [CNT_W-1:0]  shiftCnt,
  input  logic [WIDTH-1:0]  radicandIn,
  output logic [HALF_W-1:0] root
);

  localparam logic [HALF_W:0]  INIT_ROOT = (HALF_W+1)'(1) << (HALF_W - 1);
  localparam logic [WIDTH-1:0] INIT_SQ   = WIDTH'(1) << (WIDTH - 2);
  localparam logic [HALF_W:0]  ROOT_MAX  = {1'b0, {HALF_W{1'b1}}};

  logic [WIDTH-1:0]  radicand;
  logic [HALF_W:0]   trialRoot;
  logic [SQ_W-1:0]   trialSq;
  logic [HALF_W-1:0] incr;
  logic [WIDTH-1:0]  incrSq;
  logic [HALF_W-1:0] rootQ;

  // Step datapath
  logic [HALF_W-1:0] nextIncr;
  logic [WIDTH-1:0]  nextIncrSq;
  logic [SQ_W-1:0]   crossTerm;
  logic [SQ_W-1:0]   radExt;
  logic              goUp;

  always_comb begin
    nextIncr   = incr >> 1;
    nextIncrSq = incrSq >> 2;
    crossTerm  = SQ_W'(trialRoot) << shiftCnt;
    radExt     = SQ_W'(radicand);
    goUp       = (radExt >= trialSq);
  end

  // Correction datapath
  logic [SQ_W-1:0] lowBound;
  logic [SQ_W-1:0] highBound;
  logic [HALF_W:0] rounded;
  logic [HALF_W:0] clamped;

  always_comb begin
    lowBound  = trialSq - SQ_W'(trialRoot);
    highBound = trialSq + SQ_W'(trialRoot);
    if (radExt <= lowBound)      rounded = trialRoot - 1'b1;
    else if (radExt > highBound) rounded = trialRoot + 1'b1;
    else                         rounded = trialRoot;
    clamped = (rounded > ROOT_MAX) ? ROOT_MAX : rounded;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      radicand  <= '0;
      trialRoot <= '0;
      trialSq   <= '0;
      incr      <= '0;
      incrSq    <= '0;
      rootQ     <= '0;
    end else begin
      if (strobe.load) begin
        radicand  <= radicandIn;
        trialRoot <= INIT_ROOT;
        trialSq   <= SQ_W'(INIT_SQ);
        incr      <= INIT_ROOT[HALF_W-1:0];
        incrSq    <= INIT_SQ;
      end
      if (strobe.step) begin
        incr   <= nextIncr;
        incrSq <= nextIncrSq;
        if (goUp) begin
          trialSq   <= trialSq + crossTerm + SQ_W'(nextIncrSq);
          trialRoot <= trialRoot + (HALF_W+1)'(nextIncr);
        end else begin
          trialSq   <= trialSq - crossTerm + SQ_W'(nextIncrSq);
          trialRoot <= trialRoot - (HALF_W+1)'(nextIncr);
        end
      end
      if (strobe.fix) rootQ <= clamped[HALF_W-1:0];
    end
  end

  assign root = rootQ;

  // Checks on the registered result against the captured operand
  logic [SQ_W-1:0] chkSq;
  logic [SQ_W-1:0] chkRoot;
  always_comb begin
    chkRoot = SQ_W'(rootQ);
    chkSq   = chkRoot * chkRoot;
  end

  assert_root_positive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.step |-> (trialRoot != '0));

  assert_nearest_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fix |=> ((rootQ == ROOT_MAX[HALF_W-1:0]) || (radExt <= chkSq + chkRoot)));

  assert_nearest_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fix |=> ((rootQ == '0) ? (radExt == '0) : (radExt + chkRoot > chkSq)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.fix |=> $stable(rootQ));

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
  import isqrt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDTH-1:0]     radicand,
  output logic                 busy,
  output logic                 done,
  output logic [WIDTH/2-1:0]   root
);

  localparam int HALF_W = WIDTH / 2;
  localparam int CNT_W  = $clog2(HALF_W);
  localparam int SQ_W   = WIDTH + 2;

  sqStrobe_t        strobe;
  logic [CNT_W-1:0] shiftCnt;

  isqrt_ctrl #(
    .HALF_W (HALF_W),
    .CNT_W  (CNT_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .strobe   (strobe),
    .shiftCnt (shiftCnt),
    .busy     (busy),
    .done     (done)
  );

  isqrt_datapath #(
    .WIDTH  (WIDTH),
    .HALF_W (HALF_W),
    .CNT_W  (CNT_W),
    .SQ_W   (SQ_W)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .shiftCnt   (shiftCnt),
    .radicandIn (radicand),
    .root       (root)
  );

endmodule

// File: tb/test_isqrt_unit.sv
module test_isqrt_unit;

  localparam int WIDTH  = 16;
  localparam int HALF_W = WIDTH / 2;
  localparam int MAXR   = (1 << HALF_W) - 1;
  localparam int NVEC   = 15;

  // Directed vectors: radicand and nearest-rounded, clamped root
  localparam int unsigned VEC_N [NVEC] = '{1739, 0, 1, 2, 3, 16, 20, 21, 56, 57,
                                           255, 65024, 65280, 65281, 65535};
  localparam int unsigned VEC_R [NVEC] = '{42, 0, 1, 1, 2, 4, 4, 5, 7, 8,
                                           16, 255, 255, 255, 255};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [WIDTH-1:0]  radicand = '0;
  logic              busy;
  logic              done;
  logic [HALF_W-1:0] root;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  isqrt_unit #(.WIDTH(WIDTH)) i_isqrt_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .radicand (radicand),
    .busy     (busy),
    .done     (done),
    .root     (root)
  );

  function automatic int unsigned refRoot(int unsigned n);
    int unsigned r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    if (n > r * r + r) r++;
    if (r > MAXR) r = MAXR;
    return r;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Launch one operation; returns the root and the edges from accept to done.
  // holdStart keeps start asserted with another operand through the done cycle.
  task automatic runOp(input int unsigned n, input bit holdStart,
                       output int unsigned res, output int lat);
    @(negedge clk);
    start    = 1'b1;
    radicand = WIDTH'(n);
    @(negedge clk);
    if (holdStart) radicand = WIDTH'(n ^ 16'h5a5a);
    else           start    = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = root;
    if (holdStart) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R3: watchdog expired, actual no completion expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned res;
    int          lat;

    // R1: reset values during and after reset
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 root in reset", root, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 root after reset", root, 0);

    // R2: busy follows the accepting edge
    @(negedge clk);
    start = 1'b1;
    radicand = 16'd1739;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    check("R4 worked example 1739", root, 42);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
    check("R2 busy cleared", busy, 0);

    // Directed vector table: R4 rounding, R5 clamp, R3 latency
    for (int v = 0; v < NVEC; v++) begin
      runOp(VEC_N[v], 1'b0, res, lat);
      check($sformatf("R4/R5 vector n=%0d", VEC_N[v]), res, VEC_R[v]);
      check("R3 latency", lat, HALF_W);
    end

    // R6: start held during busy and the done cycle is ignored
    runOp(1739, 1'b1, res, lat);
    check("R6 result under held start", res, 42);
    check("R6 latency under held start", lat, HALF_W);
    check("R6 idle after done", busy, 0);
    @(negedge clk);
    check("R6 no restart", busy, 0);
    check("R7 root held while idle", root, 42);
    repeat (3) @(negedge clk);
    check("R7 root held later", root, 42);

    // Sweeps: low range, clamp region, and a strided pass over the full range
    for (int n = 0; n < 300; n++) begin
      runOp(n, 1'b0, res, lat);
      check($sformatf("R4 low n=%0d", n), res, refRoot(n));
    end
    for (int n = 65236; n < 65536; n++) begin
      runOp(n, 1'b0, res, lat);
      check($sformatf("R5 top n=%0d", n), res, refRoot(n));
    end
    for (int n = 3; n < 65536; n += 7) begin
      runOp(n, 1'b0, res, lat);
      check($sformatf("R4 sweep n=%0d", n), res, refRoot(n));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule